// File: doc/BRIEF.md
# Register-Controlled SPI Master

This block is an SPI master placed behind a small word-addressed register port. Software writes a word to the transmit holding register. The shifter picks the word up as soon as it is idle and clocks it out most significant bit first on `mosi`. At the same time it collects the same number of bits from `miso`. When the word is complete, the received bits go into the receive data register and a ready flag is raised.

Both directions are single-buffered. A late read of received data does not block the next word. The new word overwrites the held one and sets a receive-overrun flag. A transmit write that arrives while the holding register is still occupied is thrown away and sets a transmit-overrun flag.

A status register reports the flags. A control register enables the interrupt sources and can force the slave selects low. A mask register picks which active-low slave-select lines the transfer uses. The serial link runs in mode 0: `sclk` idles low, data is sampled on the rising edge and changed on the falling edge. One serial clock period is `2*HALF_DIV` system clocks.

The shifter is a four-state machine:

| State | `sclk` | What happens |
|---|---|---|
| `SH_IDLE` | low | Waits for a held word. |
| `SH_LOW` | low | Lasts `HALF_DIV` clocks. `miso` is latched when the state ends. |
| `SH_HIGH` | high | Lasts `HALF_DIV` clocks. |
| `SH_TAIL` | low | Lasts `HALF_DIV` clocks and keeps the select low after the last bit. |

Its transitions are:
- `go`: from `SH_IDLE` to `SH_LOW` when a held word exists. This is the handoff that frees the holding register.
- `rise`: from `SH_LOW` to `SH_HIGH`.
- `fall`: from `SH_HIGH` to `SH_LOW` when bits remain. The word shifts one place on this transition.
- `last`: from `SH_HIGH` to `SH_TAIL` after bit `DATA_W-1`. The received word is delivered on this transition.
- `release`: from `SH_TAIL` to `SH_IDLE`.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the following hold:
  - status reads `0x60`: bit 6, transmit-ready, and bit 5, empty, are set; all other bits are 0.
  - control reads 0.
  - the select mask reads 1.
  - `irq` is 0, `sclk` is 0 and every `ss_n` line is 1.
- R2: The registers sit at word addresses 0 to 5:

  | Address | Register |
  |---|---|
  | 0 | receive data |
  | 1 | transmit data |
  | 2 | status |
  | 3 | control |
  | 4 | reserved |
  | 5 | select mask |

  Control keeps only bits 3, 4, 6, 7, 8 and 10. The mask keeps only its low `NUM_SS` bits. Every other read bit, and the reserved address, read 0.
- R3: A write to address 1 loads the holding register and clears transmit-ready (status bit 6) at the next edge. Transmit-ready returns to 1 one cycle later, when the shifter takes the word. Empty (status bit 5) is 1 only when no word is held and no transfer is running.
- R4: A write to address 1 while transmit-ready is 0 sets the transmit-overrun flag (status bit 4). The new word is discarded, and the word that was already held is the one transmitted.
- R5: Each transfer gives exactly `DATA_W` rising `sclk` edges with a period of `2*HALF_DIV` clocks. `mosi` carries the word MSB first and changes only while `sclk` is low. `miso` is sampled on each rising edge.
- R6: A completed word is copied into receive data (address 0) and sets receive-ready (status bit 7). A read of address 0 clears receive-ready. A write to address 0 changes nothing.
- R7: If receive-ready is still 1 when a new word completes, the receive-overrun flag (status bit 3) is set and receive data holds the newest word.
- R8: Status bit 8 is the OR of the two overrun flags. Any write to address 2, whatever the data, clears bits 3, 4 and 8.
- R9: `irq` is the OR of these five terms:
  - receive-overrun AND control bit 3
  - transmit-overrun AND control bit 4
  - transmit-ready AND control bit 6
  - receive-ready AND control bit 7
  - status bit 8 AND control bit 8
- R10: `ss_n[i]` is 0 only when mask bit i is 1 and either a transfer is running or control bit 10 is 1. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Word address of the register access |
| reg_rd | input | 1 | Read strobe; a read of address 0 clears receive-ready |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
The assertions check the following on every clock:
- a dropped transmit write leaves the held word unchanged and raises its flag.
- the shifter's handoff always frees the holding register.
- a completed word always raises receive-ready, and raises receive-overrun when it lands on unread data.
- a status write clears the error flags.
- `mosi` holds steady while `sclk` is high.

Only the bench scenarios can show the rest, because it needs a serial partner:
- the bit order seen on the wire and the word assembled from `miso`.
- the serial clock period and edge count.
- the select pattern during a transfer and under the force bit.
- the exact cycle at which transmit-ready falls and returns.
- that the ignored receive-data write leaves the held word intact.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_TAIL
    } sh_state_e;

    localparam logic [2:0] A_RX   = 3'd0;
    localparam logic [2:0] A_TX   = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_CTRL = 3'd3;
    localparam logic [2:0] A_MASK = 3'd5;

    localparam int B_ROE  = 3;
    localparam int B_TOE  = 4;
    localparam int B_TMT  = 5;
    localparam int B_TRDY = 6;
    localparam int B_RRDY = 7;
    localparam int B_ERR  = 8;
    localparam int B_SSO  = 10;

    localparam logic [10:0] CTRL_KEEP = 11'h5D8;
endpackage

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter #(
    parameter int W        = 8,
    parameter int HALF_DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx_word,
    output logic         take,
    output logic         busy,
    output logic         rx_done,
    output logic [W-1:0] rx_word,
    output logic         sclk,
    output logic         mosi,
    input  logic         miso
);
    import spim_pkg::*;

    localparam int CW = $clog2(HALF_DIV) + 1;
    localparam int BW = $clog2(W) + 1;

    sh_state_e      state, nxt;
    logic [CW-1:0]  cnt;
    logic [BW-1:0]  bit_cnt;
    logic [W-1:0]   sh;
    logic           smp;
    logic [W:0]     cat;
    logic           phase_end;
    logic           last_bit;

    assign phase_end = (cnt == CW'(HALF_DIV - 1));
    assign last_bit  = (bit_cnt == BW'(W - 1));
    assign cat       = {sh, smp};

    always_comb begin
        nxt = state;
        unique case (state)
            SH_IDLE: if (start)     nxt = SH_LOW;
            SH_LOW:  if (phase_end) nxt = SH_HIGH;
            SH_HIGH: if (phase_end) nxt = last_bit ? SH_TAIL : SH_LOW;
            SH_TAIL: if (phase_end) nxt = SH_IDLE;
            default:                nxt = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_cnt <= '0;
            sh      <= '0;
            smp     <= 1'b0;
            rx_done <= 1'b0;
            rx_word <= '0;
        end else begin
            rx_done <= 1'b0;
            if (state == SH_IDLE || phase_end) cnt <= '0;
            else                               cnt <= cnt + 1'b1;
            unique case (state)
                SH_IDLE: if (start) begin
                    sh      <= tx_word;
                    bit_cnt <= '0;
                end
                SH_LOW: if (phase_end) smp <= miso;
                SH_HIGH: if (phase_end) begin
                    if (last_bit) begin
                        rx_word <= cat[W-1:0];
                        rx_done <= 1'b1;
                    end else begin
                        sh      <= cat[W-1:0];
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                SH_TAIL: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        take = (state == SH_IDLE) && start;
        busy = (state != SH_IDLE);
        sclk = (state == SH_HIGH);
        mosi = busy ? sh[W-1] : 1'b0;
    end

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R5
endmodule

// File: rtl/spim_regs.sv
`timescale 1ns/1ps
module spim_regs #(
    parameter int W   = 8,
    parameter int NSS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     addr,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata,
    input  logic           take,
    input  logic           busy,
    input  logic           rx_done,
    input  logic [W-1:0]   rx_word,
    output logic [W-1:0]   tx_word,
    output logic           tx_full,
    output logic [NSS-1:0] ss_mask,
    output logic           sso,
    output logic           irq
);
    import spim_pkg::*;

    logic [W-1:0] rx_q;
    logic         rrdy, roe, toe;
    logic [10:0]  ctrl;
    logic         trdy, tmt, err;
    logic         wr_tx, wr_stat, rd_rx;

    assign wr_tx   = wr_en && (addr == A_TX);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign rd_rx   = rd_en && (addr == A_RX);
    assign trdy    = !tx_full;
    assign tmt     = !tx_full && !busy;
    assign err     = roe || toe;
    assign sso     = ctrl[B_SSO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_word <= '0;
            tx_full <= 1'b0;
            toe     <= 1'b0;
        end else begin
            if (wr_stat) toe <= 1'b0;
            if (wr_tx) begin
                if (tx_full) toe <= 1'b1;
                else begin
                    tx_word <= wdata[W-1:0];
                    tx_full <= 1'b1;
                end
            end
            if (take) tx_full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
            rrdy <= 1'b0;
            roe  <= 1'b0;
        end else begin
            if (wr_stat) roe  <= 1'b0;
            if (rd_rx)   rrdy <= 1'b0;
            if (rx_done) begin
                rx_q <= rx_word;
                rrdy <= 1'b1;
                if (rrdy && !rd_rx) roe <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            ss_mask <= NSS'(1);
        end else if (wr_en) begin
            if (addr == A_CTRL) ctrl    <= wdata[10:0] & CTRL_KEEP;
            if (addr == A_MASK) ss_mask <= wdata[NSS-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_RX:   rdata[W-1:0] = rx_q;
            A_STAT: begin
                rdata[B_ROE]  = roe;
                rdata[B_TOE]  = toe;
                rdata[B_TMT]  = tmt;
                rdata[B_TRDY] = trdy;
                rdata[B_RRDY] = rrdy;
                rdata[B_ERR]  = err;
            end
            A_CTRL: rdata[10:0]    = ctrl;
            A_MASK: rdata[NSS-1:0] = ss_mask;
            default: rdata = '0;
        endcase
    end

    assign irq = (roe && ctrl[B_ROE]) || (toe && ctrl[B_TOE]) ||
                 (trdy && ctrl[B_TRDY]) || (rrdy && ctrl[B_RRDY]) ||
                 (err && ctrl[B_ERR]);

    AST_TOE_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && tx_full) |=> (toe && $stable(tx_word))); // R4
    AST_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !tx_full); // R3
    AST_RX_SETS_RRDY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rrdy); // R6
    AST_LATE_RX_ROE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rrdy && !rd_rx) |=> roe); // R7
    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !rx_done) |=> (!roe && !toe)); // R8
endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl #(
    parameter int DATA_W   = 8,
    parameter int NUM_SS   = 4,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n
);
    logic              start, take, busy, rx_done, sso;
    logic [DATA_W-1:0] tx_word, rx_word;
    logic [NUM_SS-1:0] ss_mask;

    spim_regs #(.W(DATA_W), .NSS(NUM_SS)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .rd_en(reg_rd),
        .wr_en(reg_wr), .wdata(reg_wdata), .rdata(reg_rdata),
        .take(take), .busy(busy), .rx_done(rx_done), .rx_word(rx_word),
        .tx_word(tx_word), .tx_full(start), .ss_mask(ss_mask),
        .sso(sso), .irq(irq)
    );

    spim_shifter #(.W(DATA_W), .HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .take(take), .busy(busy), .rx_done(rx_done), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
        assign ss_n[i] = !(ss_mask[i] && (busy || sso));
    end

    AST_SS_WHEN_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (ss_n == ~ss_mask)); // R10
endmodule

// File: tb/spim_ctrl_bench.sv
`timescale 1ns/1ps
module spim_ctrl_bench;
    localparam int W = 8;
    localparam int NSS = 4;
    localparam int HD = 2;

    logic clk = 0, rst_n = 0;
    logic [2:0] reg_addr = 0;
    logic reg_rd = 0, reg_wr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic irq, sclk, mosi, miso;
    logic [NSS-1:0] ss_n;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spim_ctrl #(.DATA_W(W), .NUM_SS(NSS), .HALF_DIV(HD)) u_spim_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    // serial partner: shifts its word out, records what arrives
    logic [W-1:0] slv_word = 0, slv, cap;
    logic slv_load = 0, mon_clr = 0;
    int rises;
    realtime t_last, t_per;
    logic [NSS-1:0] ss_seen;
    assign miso = slv[W-1];

    always @(negedge sclk or posedge slv_load)
        if (slv_load) slv <= slv_word;
        else          slv <= {slv[W-2:0], 1'b0};

    always @(posedge sclk or posedge mon_clr)
        if (mon_clr) begin
            cap <= 0; rises <= 0; t_per <= 0; t_last <= 0; ss_seen <= '1;
        end else begin
            cap <= {cap[W-2:0], mosi};
            rises <= rises + 1;
            t_per <= $realtime - t_last;
            t_last <= $realtime;
            ss_seen <= ss_n;
        end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic arm(input logic [W-1:0] sw);
        slv_word = sw;
        slv_load = 1; mon_clr = 1;
        #1 slv_load = 0; mon_clr = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            rd(3'd2, s);
            if (s[5]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd2, d); chk(d == 32'h60, "R1 status", d, 32'h60);
        rd(3'd3, d); chk(d == 0, "R1 control", d, 0);
        rd(3'd5, d); chk(d == 1, "R1 mask", d, 1);
        chk(!irq && !sclk && ss_n == '1, "R1 pins", {irq, sclk, ss_n}, {2'b0, 4'hF});
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d); chk(d == 32'h5D8, "R2 control bits", d, 32'h5D8);
        wr(3'd3, 0);
        wr(3'd5, 32'hFFFF_FFF5);
        rd(3'd5, d); chk(d == 32'h5, "R2 mask bits", d, 32'h5);
        wr(3'd5, 1);
        rd(3'd4, d); chk(d == 0, "R2 reserved", d, 0);
        rd(3'd1, d); chk(d == 0, "R2 tx reads zero", d, 0);
    endtask

    task automatic t_xfer();
        logic [31:0] d;
        arm(8'hA5);
        wr(3'd1, 32'h3C);
        rd(3'd2, d); chk(d[6:5] == 2'b00, "R3 trdy low after write", d, 32'h0);
        rd(3'd2, d); chk(d[6:5] == 2'b10, "R3 trdy back, busy", d, 32'h40);
        wait_idle();
        chk(cap == 8'h3C, "R5 mosi msb first", cap, 8'h3C);
        chk(rises == W, "R5 rising edges", rises, W);
        chk(t_per == 2 * HD * 8.0, "R5 sclk period", int'(t_per), 2 * HD * 8);
        chk(ss_seen == 4'b1110, "R10 ss during transfer", ss_seen, 4'b1110);
        chk(ss_n == 4'hF, "R10 ss released", ss_n, 4'hF);
        rd(3'd2, d); chk(d == 32'hE0, "R6 rrdy set", d, 32'hE0);
        wr(3'd0, 32'hFF);
        rd(3'd0, d); chk(d == 32'hA5, "R6 rxdata, write ignored", d, 32'hA5);
        rd(3'd2, d); chk(d == 32'h60, "R6 rrdy cleared by read", d, 32'h60);
    endtask

    task automatic t_toe();
        logic [31:0] d;
        arm(8'h00);
        wr(3'd1, 32'h81);
        wr(3'd1, 32'h7E);
        rd(3'd2, d); chk(d[8] && d[4], "R4 toe and e set", d, 32'h110);
        wait_idle();
        chk(cap == 8'h81, "R4 dropped word not sent", cap, 8'h81);
        wr(3'd2, 32'h0);
        rd(3'd2, d); chk(d == 32'hE0, "R8 status write clears toe/e", d, 32'hE0);
        rd(3'd0, d);
    endtask

    task automatic t_roe_irq();
        logic [31:0] d;
        arm(8'h11); wr(3'd1, 32'h1); wait_idle();
        arm(8'hC3); wr(3'd1, 32'h2); wait_idle();
        rd(3'd2, d); chk(d == 32'h1E8, "R7 roe set, e set", d, 32'h1E8);
        wr(3'd3, 32'h100);
        #1 chk(irq == 1, "R9 irq from error", irq, 1);
        wr(3'd3, 32'h008);
        #1 chk(irq == 1, "R9 irq from roe", irq, 1);
        wr(3'd3, 32'h010);
        #1 chk(irq == 0, "R9 no irq, toe clear", irq, 0);
        rd(3'd0, d); chk(d == 32'hC3, "R7 newest word held", d, 32'hC3);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d); chk(d == 32'h60, "R8 clear any data", d, 32'h60);
        wr(3'd3, 32'h040);
        #1 chk(irq == 1, "R9 irq from trdy", irq, 1);
        wr(3'd3, 32'h080);
        #1 chk(irq == 0, "R9 rrdy clear no irq", irq, 0);
        wr(3'd3, 0);
    endtask

    task automatic t_sso();
        wr(3'd3, 32'h400);
        #1 chk(ss_n == 4'b1110, "R10 forced select", ss_n, 4'b1110);
        wr(3'd5, 32'h6);
        #1 chk(ss_n == 4'b1001, "R10 forced mask 6", ss_n, 4'b1001);
        wr(3'd3, 0);
        #1 chk(ss_n == 4'hF, "R10 force off", ss_n, 4'hF);
        wr(3'd5, 1);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        arm(8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_map();
        t_xfer();
        t_toe();
        t_roe_irq();
        t_sso();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule